// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes stereo PCM audio from a three-wire serial link and turns it into parallel samples. The link has a bit clock, a word clock whose level marks the channel, and one data line. The receiver supports three framings, chosen by a static select. Two are right-justified, one with 18-bit words and one with 16-bit words. The third is I2S with 16-bit words, where the first data bit comes one bit period after the word clock changes. Every result is sign-extended to 18 bits. A left/right pair is presented together with a one-cycle valid strobe.

All logic runs on one system clock. That clock also serves as the master clock, at 256, 384 or 512 times the sample rate. The bit clock has two possible sources. In external mode it comes from outside. It is passed through a two-flop synchroniser and its rising edges are detected, and the word clock and data lines pass through the same synchroniser. In internal mode the receiver ignores the bit-clock pin. It makes its own bit timing by dividing the master clock and restarts that division at every word-clock transition. A source that sends extra bit-clock cycles per frame in external mode is handled correctly.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is held, and on leaving it, `left_o` and `right_o` read zero and `valid_o` is low.
- R2: Format select 0 (right-justified, 18 bits) takes as the word the last 18 bits sampled before a word-clock transition, MSB first. The word belongs to the left channel when the word clock was high during those bits. Any earlier bits in that half-frame are ignored.
- R3: Format select 2 (right-justified, 16 bits; select 3 behaves the same) takes the last 16 bits before a transition, with the same channel polarity as R2. The word's bit 15 is copied into output bits 17 and 16.
- R4: Format select 1 (I2S) ignores the first bit after a word-clock transition and takes the next 16 bits as the word, MSB first. The left channel is carried while the word clock is low. Bits after the sixteenth are ignored, and the sixteenth may fall after the next transition. The result is sign-extended as in R3.
- R5: `valid_o` is high for exactly one cycle when a right word completes after a left word. `left_o` and `right_o` change only in that cycle, and both outputs hold that frame's pair.
- R6: A right word that is not preceded by a left word since the last pair raises no strobe, so the number of strobes equals the number of complete frames sent.
- R7: With `int_clk_i` high, one bit lasts N system clocks, starting at the word-clock transition, and data is sampled at mid-bit. For ratio select 0/1/2 (256/384/512 system clocks per frame), N is 4/8/8 in the 18-bit format and 8/8/16 in the other two formats.
- R8: With `int_clk_i` low, data is sampled on each synchronised rising edge of `sclk_i`. Any half-frame length from the word size up to 32 bits is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| int_clk_i | input | 1 | 1 = bit timing divided from clk, 0 = external bit clock |
| fmt_i | input | 2 | 0 = right-justified 18, 1 = I2S 16, 2/3 = right-justified 16 |
| ratio_i | input | 2 | Internal mode frame length: 0 = 256, 1 = 384, 2 = 512 clocks |
| sclk_i | input | 1 | External bit clock |
| lrck_i | input | 1 | Word clock |
| sdata_i | input | 1 | Serial data |
| left_o | output | 18 | Left sample, sign-extended |
| right_o | output | 18 | Right sample, sign-extended |
| valid_o | output | 1 | One-cycle strobe for a new pair |

## Verification
Each format is tried with an external bit clock and with every internal ratio, so a wrong divider or a wrong sample phase shows up as shifted words. In external mode the half-frame length is chosen at random, and the bits ahead of the word are filled with random padding. This exposes a right-justified capture that starts from the transition instead of ending at it, and an I2S capture that does not stop after sixteen bits. Directed frames send the largest positive and most negative words of both widths, which separates correct sign extension from zero fill. The I2S half-frames of exactly 16 bits check that a word whose last bit arrives after the next transition is still completed.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    FMT_RJ18 = 2'd0,
    FMT_I2S  = 2'd1,
    FMT_RJ16 = 2'd2
  } fmt_e;

  parameter int BCLK_DIV_W = 5;

  // System clocks per bit in internal mode, from format and frame ratio.
  function automatic logic [BCLK_DIV_W-1:0] bit_div(input logic [1:0] fmt,
                                                    input logic [1:0] ratio);
    logic long_w;
    long_w = (fmt == FMT_RJ18);
    case (ratio)
      2'd1:    bit_div = 5'd8;
      2'd2:    bit_div = long_w ? 5'd8 : 5'd16;
      default: bit_div = long_w ? 5'd4 : 5'd8;
    endcase
  endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [W-1:0] src;
    if (i == 0) begin : g_first
      assign src = d;
    end else begin : g_next
      assign src = stg[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= src;
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sar_bitclk.sv
module sar_bitclk
  import sar_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       int_mode,
  input  logic [1:0] fmt,
  input  logic [1:0] ratio,
  input  logic       sclk_s,
  input  logic       lrck_s,
  output logic       tick,
  output logic       wl_edge,
  output logic       lrck_prev
);

  logic                  lrck_q, sclk_q;
  logic [BCLK_DIV_W-1:0] cnt_q, cnt_d, phase, div_n;

  always_comb begin
    div_n     = bit_div(fmt, ratio);
    wl_edge   = lrck_s ^ lrck_q;
    phase     = wl_edge ? '0 : cnt_q;
    cnt_d     = (phase == div_n - 1'b1) ? '0 : phase + 1'b1;
    tick      = int_mode ? (phase == (div_n >> 1)) : (sclk_s & ~sclk_q);
    lrck_prev = lrck_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrck_q <= 1'b0;
      sclk_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      lrck_q <= lrck_s;
      sclk_q <= sclk_s;
      cnt_q  <= cnt_d;
    end
  end

  // R7: divided bit timing never samples twice in a row
  p_int_tick_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mode && tick) |=> !tick);

  // R8: each external rising edge yields a single sample
  p_ext_tick_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_mode && tick) |=> !tick);

endmodule

// File: rtl/sar_deser.sv
module sar_deser
  import sar_pkg::*;
#(
  parameter int OUT_W   = 18,
  parameter int SHORT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       fmt,
  input  logic             tick,
  input  logic             wl_edge,
  input  logic             lrck_now,
  input  logic             lrck_prev,
  input  logic             sd,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o
);

  localparam int REM_W = $clog2(SHORT_W + 1);
  localparam int EXT_W = OUT_W - SHORT_W;

  logic [OUT_W-1:0]   sh_q, sh_d, stage_q, stage_d, lo_q, lo_d, ro_q, ro_d;
  logic [1:0]         pos_q, pos_d;
  logic [REM_W-1:0]   rem_q, rem_d;
  logic               ch_q, ch_d, seen_q, seen_d, valid_q, valid_d;
  logic               is_i2s, is_long, start, done_i2s, latch, is_left;
  logic [SHORT_W-1:0] w_short;
  logic [OUT_W-1:0]   word;

  always_comb begin
    is_i2s   = (fmt == FMT_I2S);
    is_long  = (fmt == FMT_RJ18);
    sh_d     = tick ? {sh_q[OUT_W-2:0], sd} : sh_q;

    pos_d = pos_q;
    if (wl_edge)                 pos_d = '0;
    else if (tick && pos_q < 2)  pos_d = pos_q + 1'b1;

    start    = is_i2s && tick && (pos_q == 2'd1);
    done_i2s = is_i2s && tick && !start && (rem_q == REM_W'(1));
    rem_d    = rem_q;
    if (start)                        rem_d = REM_W'(SHORT_W - 1);
    else if (tick && rem_q != '0)     rem_d = rem_q - 1'b1;
    ch_d     = start ? lrck_now : ch_q;

    w_short  = is_i2s ? {sh_q[SHORT_W-2:0], sd} : sh_q[SHORT_W-1:0];
    word     = is_long ? sh_q : {{EXT_W{w_short[SHORT_W-1]}}, w_short};
    latch    = done_i2s || (!is_i2s && wl_edge);
    is_left  = is_i2s ? !ch_q : lrck_prev;

    stage_d = stage_q;
    seen_d  = seen_q;
    lo_d    = lo_q;
    ro_d    = ro_q;
    valid_d = 1'b0;
    if (latch && is_left) begin
      stage_d = word;
      seen_d  = 1'b1;
    end else if (latch) begin
      seen_d = 1'b0;
      if (seen_q) begin
        lo_d    = stage_q;
        ro_d    = word;
        valid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      pos_q   <= 2'd2;
      rem_q   <= '0;
      ch_q    <= 1'b0;
      stage_q <= '0;
      seen_q  <= 1'b0;
      lo_q    <= '0;
      ro_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      pos_q   <= pos_d;
      rem_q   <= rem_d;
      ch_q    <= ch_d;
      stage_q <= stage_d;
      seen_q  <= seen_d;
      lo_q    <= lo_d;
      ro_q    <= ro_d;
      valid_q <= valid_d;
    end
  end

  assign left_o  = lo_q;
  assign right_o = ro_q;
  assign valid_o = valid_q;

  // R5: strobe lasts one cycle
  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R5: outputs move only together with the strobe
  p_hold_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> ($stable(lo_q) && $stable(ro_q)));

  // R3: short words leave the output sign-extended
  p_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !is_long) |->
      (ro_q[OUT_W-1:SHORT_W] == {EXT_W{ro_q[SHORT_W-1]}} &&
       lo_q[OUT_W-1:SHORT_W] == {EXT_W{lo_q[SHORT_W-1]}}));

  // R4: the I2S bit budget never exceeds one short word
  p_rem_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= REM_W'(SHORT_W - 1));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sar_pkg::*;
#(
  parameter int OUT_W       = 18,
  parameter int SHORT_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_clk_i,
  input  logic [1:0]       fmt_i,
  input  logic [1:0]       ratio_i,
  input  logic             sclk_i,
  input  logic             lrck_i,
  input  logic             sdata_i,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o
);

  logic [1:0] rst_pipe;
  logic       rst_int_n;
  logic       sclk_s, lrck_s, sdata_s;
  logic       tick, wl_edge, lrck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  sar_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({sclk_i, lrck_i, sdata_i}),
    .q     ({sclk_s, lrck_s, sdata_s})
  );

  sar_bitclk u_bitclk (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .int_mode  (int_clk_i),
    .fmt       (fmt_i),
    .ratio     (ratio_i),
    .sclk_s    (sclk_s),
    .lrck_s    (lrck_s),
    .tick      (tick),
    .wl_edge   (wl_edge),
    .lrck_prev (lrck_prev)
  );

  sar_deser #(.OUT_W(OUT_W), .SHORT_W(SHORT_W)) u_deser (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .fmt       (fmt_i),
    .tick      (tick),
    .wl_edge   (wl_edge),
    .lrck_now  (lrck_s),
    .lrck_prev (lrck_prev),
    .sd        (sdata_s),
    .left_o    (left_o),
    .right_o   (right_o),
    .valid_o   (valid_o)
  );

endmodule

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;

  localparam int CLK_PERIOD = 10;
  localparam int SCLK_HALF  = 4;
  localparam int FRAMES     = 6;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n, int_clk, sclk, lrck, sdata;
  logic [1:0]  fmt, ratio;
  logic [17:0] left_o, right_o;
  logic        valid_o;

  int checks = 0, failures = 0;
  int mon_checks = 0, mon_fail = 0, vcnt = 0, chg_err = 0;
  int n_exp = 0;
  bit done = 0;
  logic [17:0] exp_l [0:15];
  logic [17:0] exp_r [0:15];
  logic [17:0] last_l, last_r;
  logic        last_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_audio_rx uut (
    .clk(clk), .rst_n(rst_n), .int_clk_i(int_clk), .fmt_i(fmt), .ratio_i(ratio),
    .sclk_i(sclk), .lrck_i(lrck), .sdata_i(sdata),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  function automatic logic [17:0] expect_word(input logic [1:0] f, input logic [17:0] w);
    if (f == 2'd0) return w;
    return {{2{w[15]}}, w[15:0]};
  endfunction

  function automatic string req_tag(input logic [1:0] f, input logic im);
    string a, b;
    a = (f == 2'd0) ? "R2" : (f == 2'd1) ? "R4" : "R3";
    b = im ? "R7" : "R8";
    return {a, " ", b};
  endfunction

  // Monitor: compares each strobed pair with the queued expectation.
  always @(negedge clk) begin
    if (!rst_n) begin
      vcnt   = 0;
      last_v = 1'b0;
      last_l = left_o;
      last_r = right_o;
    end else begin
      if (!valid_o && (left_o != last_l || right_o != last_r)) chg_err++;
      if (valid_o) begin
        mon_checks++;
        if (last_v) begin
          mon_fail++;
          $display("FAIL R5 strobe longer than one cycle act=1 exp=0");
        end
        if (vcnt >= n_exp) begin
          mon_fail++;
          $display("FAIL R6 extra strobe act=%0d exp=%0d", vcnt + 1, n_exp);
        end else begin
          mon_checks += 2;
          if (left_o !== exp_l[vcnt]) begin
            mon_fail++;
            $display("FAIL %s left word %0d act=%h exp=%h", req_tag(fmt, int_clk), vcnt, left_o, exp_l[vcnt]);
          end
          if (right_o !== exp_r[vcnt]) begin
            mon_fail++;
            $display("FAIL %s right word %0d act=%h exp=%h", req_tag(fmt, int_clk), vcnt, right_o, exp_r[vcnt]);
          end
        end
        vcnt++;
      end
      last_v = valid_o;
      last_l = left_o;
      last_r = right_o;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
    end
  endtask

  task automatic drive_bit(input logic b, input logic lvl, input int n);
    if (int_clk) begin
      lrck  = lvl;
      sdata = b;
      repeat (n) @(negedge clk);
    end else begin
      sclk  = 1'b0;
      lrck  = lvl;
      sdata = b;
      repeat (SCLK_HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (SCLK_HALF) @(negedge clk);
    end
  endtask

  task automatic send_half(input logic lvl, input logic [17:0] w, input logic [17:0] prevw,
                           input int nhalf, input int n);
    int wl;
    logic b;
    wl = (fmt == 2'd0) ? 18 : 16;
    for (int idx = 0; idx < nhalf; idx++) begin
      b = 1'($urandom);
      if (fmt == 2'd1) begin
        if (idx == 0 && nhalf == 16) b = prevw[0];
        else if (idx >= 1 && idx <= 16) b = w[16-idx];
      end else if (idx >= nhalf - wl) begin
        b = w[nhalf-1-idx];
      end
      drive_bit(b, lvl, n);
    end
  endtask

  function automatic int pick_half(input logic [1:0] f);
    int lo;
    lo = (f == 2'd0) ? 18 : 16;
    return lo + int'($urandom % (33 - lo));
  endfunction

  task automatic run_group(input logic im, input logic [1:0] f, input logic [1:0] r);
    logic        left_lvl;
    int          bpf, n, nh, rclk;
    logic [17:0] l, rw, prevw;
    rst_n   = 1'b0;
    int_clk = im;
    fmt     = f;
    ratio   = r;
    left_lvl = (f == 2'd1) ? 1'b0 : 1'b1;
    sclk    = 1'b0;
    lrck    = ~left_lvl;
    sdata   = 1'b0;
    n_exp   = 0;
    chg_err = 0;
    repeat (3) @(negedge clk);
    check(left_o == 18'd0 && right_o == 18'd0 && valid_o == 1'b0, "R1",
          "outputs in reset", {left_o[15:0], right_o[15:0]}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(left_o == 18'd0 && right_o == 18'd0 && valid_o == 1'b0, "R1",
          "outputs after reset", {left_o[15:0], right_o[15:0]}, 32'd0);
    repeat (300) @(negedge clk);
    rclk = (r == 2'd1) ? 384 : (r == 2'd2) ? 512 : 256;
    bpf  = (r == 2'd1) ? 48 : (f == 2'd0) ? 64 : 32;
    n    = rclk / bpf;
    prevw = 18'd0;
    for (int k = 0; k < FRAMES; k++) begin
      l  = 18'($urandom);
      rw = 18'($urandom);
      if (k == 0) begin l = 18'h1FFFF; rw = 18'h20000; end
      if (k == 1) begin l = 18'h37FFF; rw = 18'h08000; end
      exp_l[n_exp] = expect_word(f, l);
      exp_r[n_exp] = expect_word(f, rw);
      n_exp++;
      nh = im ? bpf / 2 : pick_half(f);
      send_half(left_lvl, l, prevw, nh, n);
      prevw = l;
      nh = im ? bpf / 2 : pick_half(f);
      send_half(~left_lvl, rw, prevw, nh, n);
      prevw = rw;
    end
    nh = im ? bpf / 2 : 16;
    send_half(left_lvl, 18'd0, prevw, nh, n);
    repeat (600) @(negedge clk);
    check(vcnt == n_exp, "R6", "strobe count", vcnt, n_exp);
    check(chg_err == 0, "R5", "outputs changed without strobe", chg_err, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; int_clk = 1'b0; fmt = 2'd0; ratio = 2'd0;
    sclk = 1'b0; lrck = 1'b0; sdata = 1'b0;
    @(negedge clk);
    for (int f = 0; f < 3; f++) begin
      run_group(1'b0, 2'(f), 2'd0);
      for (int r = 0; r < 3; r++) run_group(1'b1, 2'(f), 2'(r));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, failures + mon_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks + 1, failures + mon_fail + 1);
      $finish;
    end
  end

endmodule